// File: doc/BRIEF.md
# Shared Lock Bank with Read-to-Acquire Registers

This block gives several bus masters a set of hardware mutual-exclusion flags. Each flag sits behind its own 32-bit word on a simple register bus with read strobe, write strobe, byte address and write data. Reading a flag's word is an atomic test-and-set. The data returns whether the flag was free, and the same clock edge marks it held. Writing zero to the word frees the flag again. When two masters race for one flag, the bus arbiter puts their reads in order, so exactly one of them reads zero.

Two read-only words describe the bank. One word has a bit for each of the lowest 32 flags. The other word gives the number of flags as a two-bit exponent code, from which software works out the count. The flag count is a parameter, and a synchronous reset frees every flag.

Top module: `hwlock_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every lock is released. After reset, the occupancy word reads 0 and every lock reads as free.
- R2: A read of a free lock at byte offset 0x100 + 4*i (i below NUM_LOCKS) returns 32'h0 and leaves lock i held from that same edge on.
- R3: A read of a held lock returns 32'h1 and changes no lock.
- R4: A write of 32'h0 to the word of lock i releases lock i.
- R5: A write of any nonzero value to a lock word changes no lock.
- R6: The word at offset 0x10 has bit i set exactly when lock i is held, for i from 0 to 31. Locks at index 32 and above are not shown, and writes to this word change nothing.
- R7: The word at offset 0x0 reads with bits 29:28 equal to log2(NUM_LOCKS) - 4 (code 1 = 32 locks, 2 = 64, 3 = 128; code 0 is unsupported) and all other bits 0. Writes to it change nothing.
- R8: A read at any other offset returns 0, and a write there changes no lock. This covers offsets that are not word aligned and lock indices at or above NUM_LOCKS.
- R9: Read data is registered. It appears in the cycle after the read strobe and is 32'h0 in any cycle that follows a cycle without a read.
- R10: When read and write strobes are both high in one cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, frees every lock |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid in the cycle after bus_rd |

## Verification
The bench builds the bank with NUM_LOCKS = 64 and ADDR_W = 12. With that count the exponent code is 2 rather than the common 1. Locks 32 to 63 exist but stay out of the occupancy word, which tests that those bits are truncated. The first address past the last lock (0x200) decodes as undefined. A sweep takes and then frees all 64 locks, and the occupancy word is read at each step.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int unsigned SYS_OFF   = 'h000;
  localparam int unsigned OCC_OFF   = 'h010;
  localparam int unsigned LOCK_BASE = 'h100;
  localparam int unsigned CODE_LSB  = 28;

  // exponent code advertised in the system word: count = 1 << (4 + code)
  function automatic logic [1:0] count_code(input int unsigned n);
    int unsigned c;
    c = $clog2(n) - 4;
    if (c > 3) c = 0;
    return c[1:0];
  endfunction
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_sys,
  output logic              sel_occ,
  output logic              sel_lock,
  output logic [LIDX_W-1:0] lock_idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-3:0] LIMIT  = (ADDR_W-2)'(NUM_LOCKS);

  logic              aligned;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    rel      = addr - BASE_A;
    sel_sys  = (addr == ADDR_W'(SYS_OFF));
    sel_occ  = (addr == ADDR_W'(OCC_OFF));
    sel_lock = aligned && (addr >= BASE_A) && (rel[ADDR_W-1:2] < LIMIT);
    lock_idx = rel[LIDX_W+1:2];
  end
endmodule

// File: rtl/hwlock_cells.sv
module hwlock_cells #(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_en,
  input  logic                 free_en,
  input  logic [LIDX_W-1:0]    idx,
  output logic [NUM_LOCKS-1:0] held
);
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_cell
    logic hit;
    assign hit = (idx == LIDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)                 held[i] <= 1'b0;
      else if (take_en && hit) held[i] <= 1'b1;
      else if (free_en && hit) held[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hwlock_rdmux.sv
module hwlock_rdmux
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS),
  localparam int unsigned OCC_W    = (NUM_LOCKS < 32) ? NUM_LOCKS : 32
) (
  input  logic                 rd,
  input  logic                 sel_sys,
  input  logic                 sel_occ,
  input  logic                 sel_lock,
  input  logic [LIDX_W-1:0]    lock_idx,
  input  logic [NUM_LOCKS-1:0] held,
  output logic [31:0]          rdata_nxt
);
  localparam logic [1:0] CODE = count_code(NUM_LOCKS);

  always_comb begin
    rdata_nxt = 32'h0;
    if (rd) begin
      if (sel_sys)       rdata_nxt[CODE_LSB+1:CODE_LSB] = CODE;
      else if (sel_occ)  rdata_nxt = 32'(held[OCC_W-1:0]);
      else if (sel_lock) rdata_nxt[0] = held[lock_idx];
    end
  end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned LIDX_W = $clog2(NUM_LOCKS);

  logic                 sel_sys, sel_occ, sel_lock;
  logic [LIDX_W-1:0]    lock_idx;
  logic [NUM_LOCKS-1:0] held;
  logic                 take_en, free_en;
  logic [31:0]          rdata_nxt;

  hwlock_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_dec (
    .addr(bus_addr), .sel_sys(sel_sys), .sel_occ(sel_occ),
    .sel_lock(sel_lock), .lock_idx(lock_idx)
  );

  // a read always takes the lock; setting an already held one is harmless
  assign take_en = bus_rd && sel_lock;
  assign free_en = bus_wr && !bus_rd && sel_lock && (bus_wdata == 32'h0);

  hwlock_cells #(.NUM_LOCKS(NUM_LOCKS)) u_cells (
    .clk(clk), .rst(rst), .take_en(take_en), .free_en(free_en),
    .idx(lock_idx), .held(held)
  );

  hwlock_rdmux #(.NUM_LOCKS(NUM_LOCKS)) u_mux (
    .rd(bus_rd), .sel_sys(sel_sys), .sel_occ(sel_occ), .sel_lock(sel_lock),
    .lock_idx(lock_idx), .held(held), .rdata_nxt(rdata_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 32'h0;
    else     bus_rdata <= rdata_nxt;
  end
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 sel_lock,
  input logic [LIDX_W-1:0]    lock_idx,
  input logic [NUM_LOCKS-1:0] held
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (held == '0 && bus_rdata == 32'h0));

  assert_free_read_takes_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_lock && !held[lock_idx]) |=>
      (bus_rdata == 32'h0 && held[$past(lock_idx)]));

  assert_held_read_returns_one_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_lock && held[lock_idx]) |=>
      (bus_rdata == 32'h1 && $stable(held)));

  assert_zero_write_frees_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && sel_lock && bus_wdata == 32'h0) |=>
      !held[$past(lock_idx)]);

  assert_nonzero_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_wdata != 32'h0) |=> $stable(held));

  assert_idle_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 32'h0));
endmodule

bind hwlock_bank hwlock_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sel_lock(sel_lock), .lock_idx(lock_idx), .held(held)
);

// File: tb/sim_hwlock_bank.sv
`timescale 1ns/1ps
module sim_hwlock_bank;
  localparam int unsigned N  = 64;
  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit mdl [N];

  always #10 clk = ~clk;

  hwlock_bank #(.NUM_LOCKS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic bit is_lock(input int a, output int idx);
    idx = (a - 'h100) / 4;
    return (a % 4 == 0) && a >= 'h100 && idx < N;
  endfunction

  // one bus cycle: reference model gives expected read data, then updates
  task automatic acc(input bit rd, input bit wr, input int a, input logic [31:0] d,
                     input string tag);
    logic [31:0] exp;
    int idx;
    bit lk;
    exp = 32'h0;
    lk = is_lock(a, idx);
    if (rd) begin
      if (a == 0) exp = 32'h2000_0000;
      else if (a == 'h10) begin
        for (int i = 0; i < 32; i++) exp[i] = mdl[i];
      end else if (lk) begin
        exp = {31'h0, mdl[idx]};
        mdl[idx] = 1'b1;
      end
    end else if (wr && lk && d == 32'h0) mdl[idx] = 1'b0;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    #2;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_rd = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    foreach (mdl[i]) mdl[i] = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    acc(1, 0, 'h10, 0, "R1 occupancy after reset");
    acc(1, 0, 'h0, 0, "R7 count code");
    acc(0, 1, 'h0, 32'hFFFF_FFFF, "R7 write system word");
    acc(1, 0, 'h0, 0, "R7 system word unchanged");
    acc(1, 0, 'h100, 0, "R2 take lock 0");
    acc(1, 0, 'h100, 0, "R3 lock 0 already held");
    acc(1, 0, 'h100 + 4*31, 0, "R2 take lock 31");
    acc(1, 0, 'h100 + 4*32, 0, "R2 take lock 32");
    acc(1, 0, 'h100 + 4*63, 0, "R2 take lock 63");
    acc(1, 0, 'h10, 0, "R6 occupancy hides 32 and up");
    acc(0, 1, 'h100, 32'h5, "R5 nonzero write");
    acc(1, 0, 'h100, 0, "R5 lock 0 still held");
    acc(0, 1, 'h100, 32'h0, "R4 free lock 0");
    acc(1, 0, 'h10, 0, "R4 occupancy after free");
    acc(1, 0, 'h100, 0, "R4 retake lock 0");
    acc(0, 1, 'h10, 32'h0, "R6 write occupancy word");
    acc(1, 0, 'h10, 0, "R6 occupancy unchanged");
    acc(1, 0, 'h200, 0, "R8 index past last lock");
    acc(1, 0, 'h101, 0, "R8 misaligned read");
    acc(0, 1, 'h181, 32'h0, "R8 misaligned write");
    acc(0, 1, 'h200, 32'h0, "R8 write past last lock");
    acc(1, 0, 'h180, 0, "R8 lock 32 still held");
    acc(1, 0, 'h104, 0, "R8 lock 1 untouched then taken");
    acc(0, 0, 'h100, 0, "R9 idle cycle");
    acc(1, 1, 'h100 + 4*63, 32'h0, "R10 read wins");
    acc(1, 0, 'h100 + 4*63, 0, "R10 lock 63 still held");
    do_reset();
    acc(1, 0, 'h10, 0, "R1 occupancy after second reset");
    acc(1, 0, 'h100 + 4*63, 0, "R1 lock 63 freed by reset");
    for (int i = 0; i < N; i++) begin
      acc(1, 0, 'h100 + 4*i, 0, "R2 sweep take");
      acc(1, 0, 'h10, 0, "R6 sweep occupancy");
    end
    for (int i = 0; i < N; i++) begin
      acc(0, 1, 'h100 + 4*i, 32'h0, "R4 sweep free");
      acc(1, 0, 'h10, 0, "R6 sweep occupancy");
    end
    acc(0, 0, 0, 0, "R9 final idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule